// File: doc/BRIEF.md
# Bandwidth-Adaptive Allocation Controller

This block decides, once per measurement window, whether the DRAM-cache allocation path should pass only pages promoted by the hot-page filter, or should skip the filter and allocate every missed page on demand. It counts main-memory transfer beats over a fixed window of clock cycles. It turns that count into a utilization fraction of peak, where peak is one beat per cycle. It then compares the fraction with a threshold supplied as an 8-bit fraction of peak.

When memory is busy, filtering is switched on so that scarce bandwidth is not spent on cold pages. When memory has spare bandwidth, filtering is switched off and more pages go into the DRAM cache. A hysteresis band below the threshold keeps the enable from toggling between adjacent windows when utilization sits near the threshold. A threshold set below the lowest utilization that filtering can reach keeps filtering on permanently.

Top module: `bw_alloc_ctrl`

## Requirements
- R1: During reset and after reset, `filter_en_o` is 1. It stays 1 at least until the first window has completed.
- R2: A window is `WINDOW_CYCLES` consecutive clock cycles, counted from the first rising edge after reset is released. `filter_en_o` changes only on the rising edge that ends a window. Between those edges it holds its value.
- R3: The utilization of a window is `beats * 256 / WINDOW_CYCLES`, in the range 0 to 256. `beats` is the number of cycles in that window, the last cycle included, in which `mem_beat_i` was 1. `WINDOW_CYCLES` is a power of two.
- R4: When filtering is off and the window utilization is strictly greater than the threshold, filtering turns on at the end of the window. A utilization equal to the threshold leaves it off.
- R5: When filtering is on and utilization + `HYST_LSB` <= threshold, filtering turns off at the end of the window. The default `HYST_LSB` is 8, so threshold 128 turns filtering off at utilization 120 but not at 121.
- R6: When filtering is on and utilization lies strictly between threshold − `HYST_LSB` and the threshold plus one, filtering stays on.
- R7: When the threshold is below `HYST_LSB`, filtering, once on, never turns off, even at zero utilization.
- R8: A fully saturated window (utilization 256) turns filtering on for every threshold value, 255 included.
- R9: The beat count starts from zero in each window. Beats of one window have no effect on the decision of the next window.
- R10: The threshold is sampled only in the last cycle of a window. Values it takes earlier in the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_beat_i | input | 1 | One-cycle pulse per main-memory transfer beat |
| util_thresh_i | input | 8 | Threshold as a fraction of peak, value/256 |
| filter_en_o | output | 1 | 1 = only filter-promoted pages may allocate; 0 = allocate on every miss |

## Verification
A wrong internal state shows at the port only once per window. A lost or extra beat, a window counter that drifts, or a count that survives a window boundary moves the decision edge or flips the decision. It is therefore visible one cycle after the window's closing edge, or one window late. The bench places beat counts right at the threshold and at the hysteresis edge, where a single beat of error changes `filter_en_o`. It also checks the output at every cycle inside each window, so an edge off by one cycle is caught in the cycle it happens.

// File: rtl/bwa_pkg.sv
// Package: shared types of the bandwidth-adaptive allocation controller.
// Assumes an 8-bit fraction-of-peak representation for threshold and utilization.
package bwa_pkg;
    localparam int FRAC_W = 8;

    // Threshold: value/256 of peak bandwidth.
    typedef logic [FRAC_W-1:0] frac_t;
    // Utilization: 0..256, so one bit wider than the threshold.
    typedef logic [FRAC_W:0]   util_t;

    typedef enum logic {
        FILT_OFF = 1'b0,
        FILT_ON  = 1'b1
    } filt_state_e;
endpackage

// File: rtl/bwa_win_timer.sv
// Module: window timer. Counts WIN_CYCLES cycles and flags the last cycle of each window.
// Assumes WIN_CYCLES >= 2. The first cycle after reset release is cycle 0.
module bwa_win_timer #(
    parameter int WIN_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam int CW = $clog2(WIN_CYCLES);

    logic [CW-1:0] cnt_q;

    // Flag the final cycle of the window.
    assign last_o = (cnt_q == CW'(WIN_CYCLES - 1));

    // Advance the cycle counter and wrap it at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (last_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R2: a new window always begins right after the last cycle.
    assert_window_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (cnt_q == '0));
endmodule

// File: rtl/bwa_beat_acc.sv
// Module: beat accumulator. Sums the beat pulses of the current window.
// total_o includes the beat of the present cycle. The sum clears after the window's last cycle.
// Assumes at most one beat per cycle.
module bwa_beat_acc #(
    parameter int WIN_CYCLES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beat_i,
    input  logic                          last_i,
    output logic [$clog2(WIN_CYCLES):0]   total_o
);
    localparam int TW = $clog2(WIN_CYCLES) + 1;

    logic [TW-1:0] acc_q;

    // Running total, the current beat included.
    assign total_o = acc_q + TW'(beat_i);

    // Accumulate, and restart from zero at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (last_i) acc_q <= '0;
        else             acc_q <= total_o;
    end

    // R3: a window can never hold more beats than cycles.
    assert_total_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        total_o <= TW'(WIN_CYCLES));
    // R9: nothing carries into the next window.
    assert_window_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> (acc_q == '0));
endmodule

// File: rtl/bwa_util_scale.sv
// Module: utilization scaler. Maps a beat count of a power-of-two window to a 0..256 fraction.
// Assumes WIN_CYCLES is a power of two. A parameter picks a right or left shift.
module bwa_util_scale
    import bwa_pkg::*;
#(
    parameter int WIN_CYCLES = 256
) (
    input  logic [$clog2(WIN_CYCLES):0] total_i,
    output util_t                       util_o
);
    localparam int WL = $clog2(WIN_CYCLES);
    localparam int XW = WL + FRAC_W + 2;

    logic [XW-1:0] wide;

    generate
        if (WL >= FRAC_W) begin : g_down
            // Long window: drop the low bits of the count.
            assign wide = XW'(total_i) >> (WL - FRAC_W);
        end else begin : g_up
            // Short window: widen the count to the fraction range.
            assign wide = XW'(total_i) << (FRAC_W - WL);
        end
    endgenerate

    assign util_o = util_t'(wide);
endmodule

// File: rtl/bwa_policy.sv
// Module: policy state. Holds the filter-enable and updates it once per window, with hysteresis.
// Assumes util_i and thr_i are valid whenever last_i is 1.
module bwa_policy
    import bwa_pkg::*;
#(
    parameter int HYST = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  last_i,
    input  util_t util_i,
    input  frac_t thr_i,
    output logic  en_o
);
    localparam int CW = FRAC_W + 2;

    filt_state_e state_q, state_d;
    logic        above, well_below;

    // Compare in a widened range so that adding HYST cannot overflow.
    assign above      = CW'(util_i) > CW'(thr_i);
    assign well_below = (CW'(util_i) + CW'(HYST)) <= CW'(thr_i);

    // Choose the next state from the current state and this window's utilization.
    always_comb begin
        state_d = state_q;
        if (last_i) begin
            if (state_q == FILT_ON) begin
                if (well_below) state_d = FILT_OFF;
            end else begin
                if (above) state_d = FILT_ON;
            end
        end
    end

    // Register the state. Reset starts with filtering on.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FILT_ON;
        else        state_q <= state_d;
    end

    assign en_o = (state_q == FILT_ON);

    // R2: the output moves only at a window end.
    assert_hold_midwin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(en_o));
    // R4: utilization over threshold leaves filtering on.
    assert_turn_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && (CW'(util_i) > CW'(thr_i))) |=> en_o);
    // R5: utilization well below threshold switches filtering off.
    assert_turn_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && en_o && ((CW'(util_i) + CW'(HYST)) <= CW'(thr_i))) |=> !en_o);
    // R6: utilization inside the hysteresis band keeps filtering on.
    assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && en_o && ((CW'(util_i) + CW'(HYST)) > CW'(thr_i))) |=> en_o);
    // R7: a threshold below the band width never releases filtering.
    assert_low_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && (CW'(thr_i) < CW'(HYST))) |=> en_o);
endmodule

// File: rtl/bw_alloc_ctrl.sv
// Module: bandwidth-adaptive allocation controller (top).
// Measures memory beats over a fixed window and decides whether hot-page filtering gates DRAM-cache allocation.
// Assumes WINDOW_CYCLES is a power of two and at least 2, and at most one beat per cycle.
module bw_alloc_ctrl
    import bwa_pkg::*;
#(
    parameter int WINDOW_CYCLES = 256,
    parameter int HYST_LSB      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mem_beat_i,
    input  logic [7:0] util_thresh_i,
    output logic       filter_en_o
);
    localparam int TW = $clog2(WINDOW_CYCLES) + 1;

    logic          win_last;
    logic [TW-1:0] beat_total;
    util_t         util;

    // Window timing.
    bwa_win_timer #(.WIN_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (win_last)
    );

    // Beat counting.
    bwa_beat_acc #(.WIN_CYCLES(WINDOW_CYCLES)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_i  (mem_beat_i),
        .last_i  (win_last),
        .total_o (beat_total)
    );

    // Scaling to a fraction of peak.
    bwa_util_scale #(.WIN_CYCLES(WINDOW_CYCLES)) u_scale (
        .total_i (beat_total),
        .util_o  (util)
    );

    // Decision with hysteresis.
    bwa_policy #(.HYST(HYST_LSB)) u_policy (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (win_last),
        .util_i (util),
        .thr_i  (frac_t'(util_thresh_i)),
        .en_o   (filter_en_o)
    );
endmodule

// File: tb/bw_alloc_ctrl_tb.sv
module bw_alloc_ctrl_tb;
    localparam int WIN  = 256;
    localparam int HYST = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       beat = 1'b0;
    logic [7:0] thresh = 8'd0;
    logic       filter_en;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    bit    exp_en = 1'b1;
    string pend_req = "R1";

    bw_alloc_ctrl #(.WINDOW_CYCLES(WIN), .HYST_LSB(HYST)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_beat_i    (beat),
        .util_thresh_i (thresh),
        .filter_en_o   (filter_en)
    );

    always #4 clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit act, input bit exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: filter_en actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference decision taken from the requirements.
    function automatic bit next_en(input bit cur, input int util, input int thr);
        if (cur) return !(util + HYST <= thr);
        return util > thr;
    endfunction

    // One window. Beats come either as the first k cycles, or scattered at random with density k/WIN.
    // The threshold optionally jitters before its final value in the last cycle.
    task automatic run_window(input int k, input int thr, input bit scatter,
                              input bit jit, input string req);
        int nb = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == 0) check(filter_en, exp_en, pend_req);
            else        check(filter_en, exp_en, "R2");
            rst_n  = 1'b1;
            beat   = scatter ? (($urandom % WIN) < k) : (i < k);
            nb    += int'(beat);
            thresh = (jit && i != WIN - 1) ? 8'($urandom) : 8'(thr);
        end
        exp_en   = next_en(exp_en, nb * 256 / WIN, thr);
        pend_req = req;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(filter_en, 1'b1, "R1");

        run_window(256, 128, 0, 0, "R3");   // full load, stays on
        run_window(0,   128, 0, 0, "R5");   // idle: off
        run_window(128, 128, 0, 0, "R4");   // equal to threshold: stays off
        run_window(129, 128, 0, 0, "R4");   // one above: on
        run_window(125, 128, 0, 0, "R6");   // in band: stays on
        run_window(120, 128, 0, 0, "R5");   // band edge: off
        run_window(200, 255, 0, 1, "R10");  // jittered threshold, final 255: stays off
        run_window(256, 255, 0, 0, "R8");   // saturation beats 255
        run_window(0,   5,   0, 0, "R7");
        run_window(0,   7,   0, 0, "R7");
        run_window(0,   8,   0, 0, "R5");   // threshold equal to band: off
        run_window(250, 100, 0, 0, "R4");   // heavy window: on
        run_window(0,   100, 0, 0, "R9");   // no carry-over: off
        for (int w = 0; w < 30; w++)
            run_window(int'($urandom % 257), int'($urandom % 256), 1,
                       bit'($urandom % 2), "R6");
        @(negedge clk);
        check(filter_en, exp_en, pend_req);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule